// File: doc/BRIEF.md
# Value Block Arithmetic Engine

This engine carries out purse-style arithmetic on 16-byte value blocks held in a block memory. A value block stores one 32-bit signed two's complement amount three times and one address byte four times. Two of the copies are stored inverted. The engine reads a source block over a simple request/acknowledge memory port and validates every redundant copy. It then computes into an internal value register. Increment, decrement and restore touch only that register. Memory changes only when a transfer command writes the register back to a destination block as a complete, correctly formatted image.

A command is presented for one cycle with `cmdValid` while the engine is idle. Each accepted command ends with a single-cycle `done` pulse. An error code comes with that pulse and stays on `errCode` until the next command completes. Software builds a value block for the first time with an ordinary memory write of a correctly formatted image. That write happens outside this engine.

Top module: `value_block_engine`

## Requirements
- R1: After reset, `done`, `memReq` and `busy` are low, and the value register holds no valid content.
- R2: A source block is well formed only if all of these hold. Bytes 0-3 hold the value V, little-endian (byte 0 is bits 7:0). Bytes 4-7 hold ~V. Bytes 8-11 hold V. Bytes 12 and 14 hold the address byte A. Bytes 13 and 15 hold ~A. A malformed source ends the command with errCode 1, writes nothing and marks the register invalid.
- R3: Increment (cmdOp 0) loads the register with V + operand and reports errCode 0. It writes nothing to memory.
- R4: Decrement (cmdOp 1) loads the register with V - operand and reports errCode 0. It writes nothing to memory.
- R5: Restore (cmdOp 2) loads the register with V unchanged and reports errCode 0. It writes nothing to memory.
- R6: Transfer (cmdOp 3) writes the R2 layout to the block at `cmdAddr`. It uses the register value and the address byte A of the last source block loaded. Transfer is the only command that asserts `memWe`.
- R7: If increment or decrement overflows as a signed operation, the command reports errCode 2. The register keeps its previous value and its validity.
- R8: A transfer while the register is invalid reports errCode 3 and makes no memory access.
- R9: Each accepted command yields exactly one one-cycle `done` pulse. `errCode` holds its value between pulses. `cmdValid` is ignored while `busy` is high.
- R10: Once `memReq` rises, it stays high with `memAddr` and `memWe` stable until the cycle in which `memAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, sampled while idle |
| cmdOp | input | 2 | 0 increment, 1 decrement, 2 restore, 3 transfer |
| cmdAddr | input | ADDR_W | Source block (ops 0-2) or destination block (op 3) |
| cmdOperand | input | 32 | Signed operand for increment and decrement |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 2 | 0 ok, 1 format, 2 overflow, 3 no valid data |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Block address of the access |
| memWdata | output | 128 | Block image to write |
| memAck | input | 1 | Memory completes the request in this cycle |
| memRdata | input | 128 | Read data, valid while memAck is high |

## Verification
The value register has no port of its own, so a wrong register value stays hidden at first. It shows up at the next transfer, as a destination image whose bytes differ from those the model builds. A wrong validity flag shows up earlier, on the same transfer, as a wrong error code or as a write that should never have happened. A wrong format decision shows up at once, on the `done` pulse of that command. The memory image is compared entry by entry after every command, so a stray write is caught within one command.

// File: rtl/vbe_pkg.sv
package vbe_pkg;
  localparam int VAL_W = 32;
  localparam int BLK_W = 128;

  typedef enum logic [1:0] {
    OP_INC = 2'd0,
    OP_DEC = 2'd1,
    OP_RESTORE = 2'd2,
    OP_XFER = 2'd3
  } vbe_op_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_FORMAT = 2'd1,
    ERR_OVERFLOW = 2'd2,
    ERR_NODATA = 2'd3
  } vbe_err_e;

  typedef struct packed {
    logic latch;   // take operand
    logic capture; // take source block from memory
    logic exec;    // check format and compute
    logic noData;  // refused transfer
    logic xferOk;  // transfer written
  } vbe_strobe_t;
endpackage

// File: rtl/vbe_ctrl.sv
module vbe_ctrl
  import vbe_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              memAck,
  input  logic              regValid,
  output vbe_strobe_t       strb,
  output vbe_op_e           opReg,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              busy,
  output logic              done
);
  typedef enum logic [2:0] {S_IDLE, S_READ, S_EXEC, S_WRITE, S_DONE} state_e;
  state_e state, nextState;
  logic [ADDR_W-1:0] addrReg;

  always_comb begin
    nextState = state;
    strb = '0;
    case (state)
      S_IDLE: if (cmdValid) begin
        strb.latch = 1'b1;
        if (vbe_op_e'(cmdOp) != OP_XFER) nextState = S_READ;
        else if (regValid) nextState = S_WRITE;
        else begin
          strb.noData = 1'b1;
          nextState = S_DONE;
        end
      end
      S_READ: if (memAck) begin
        strb.capture = 1'b1;
        nextState = S_EXEC;
      end
      S_EXEC: begin
        strb.exec = 1'b1;
        nextState = S_DONE;
      end
      S_WRITE: if (memAck) begin
        strb.xferOk = 1'b1;
        nextState = S_DONE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opReg <= OP_INC;
      addrReg <= '0;
    end else begin
      state <= nextState;
      if (strb.latch) begin
        opReg <= vbe_op_e'(cmdOp);
        addrReg <= cmdAddr;
      end
    end
  end

  assign memReq = (state == S_READ) || (state == S_WRITE);
  assign memWe = (state == S_WRITE);
  assign memAddr = addrReg;
  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe))); // R10
  AST_WRITE_ONLY_XFER: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (opReg == OP_XFER)); // R6
  AST_XFER_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> regValid); // R8
endmodule

// File: rtl/vbe_dpath.sv
module vbe_dpath
  import vbe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  vbe_strobe_t      strb,
  input  vbe_op_e          opReg,
  input  logic [VAL_W-1:0] cmdOperand,
  input  logic [BLK_W-1:0] memRdata,
  output logic [BLK_W-1:0] memWdata,
  output logic             regValid,
  output logic [1:0]       errCode
);
  logic [BLK_W-1:0] srcBlk;
  logic [VAL_W-1:0] valReg, operandReg, srcVal, sumVal, diffVal;
  logic [7:0]       addrByte, srcAddr;
  logic             fmtOk, addOvf, subOvf;
  vbe_err_e         errReg;

  assign srcVal  = srcBlk[31:0];
  assign srcAddr = srcBlk[103:96];
  assign fmtOk = (srcBlk[63:32] == ~srcVal) && (srcBlk[95:64] == srcVal)
              && (srcBlk[111:104] == ~srcAddr) && (srcBlk[119:112] == srcAddr)
              && (srcBlk[127:120] == ~srcAddr);

  assign sumVal  = srcVal + operandReg;
  assign diffVal = srcVal - operandReg;
  assign addOvf = (srcVal[VAL_W-1] == operandReg[VAL_W-1]) && (sumVal[VAL_W-1] != srcVal[VAL_W-1]);
  assign subOvf = (srcVal[VAL_W-1] != operandReg[VAL_W-1]) && (diffVal[VAL_W-1] != srcVal[VAL_W-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcBlk <= '0;
      valReg <= '0;
      operandReg <= '0;
      addrByte <= '0;
      regValid <= 1'b0;
      errReg <= ERR_NONE;
    end else begin
      if (strb.latch) operandReg <= cmdOperand;
      if (strb.capture) srcBlk <= memRdata;
      if (strb.noData) begin
        errReg <= ERR_NODATA;
        regValid <= 1'b0;
      end
      if (strb.xferOk) errReg <= ERR_NONE;
      if (strb.exec) begin
        if (!fmtOk) begin
          errReg <= ERR_FORMAT;
          regValid <= 1'b0;
        end else if ((opReg == OP_INC && addOvf) || (opReg == OP_DEC && subOvf)) begin
          errReg <= ERR_OVERFLOW;
        end else begin
          errReg <= ERR_NONE;
          regValid <= 1'b1;
          addrByte <= srcAddr;
          case (opReg)
            OP_INC:  valReg <= sumVal;
            OP_DEC:  valReg <= diffVal;
            default: valReg <= srcVal;
          endcase
        end
      end
    end
  end

  assign memWdata = {~addrByte, addrByte, ~addrByte, addrByte, valReg, ~valReg, valReg};
  assign errCode = errReg;

  AST_BAD_FMT_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (strb.exec && !fmtOk) |=> (!regValid && errCode == ERR_FORMAT)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.exec && fmtOk && ((opReg == OP_INC && addOvf) || (opReg == OP_DEC && subOvf)))
    |=> ($stable(valReg) && $stable(regValid) && errCode == ERR_OVERFLOW)); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.exec || strb.noData || strb.xferOk) |=> $stable(errCode)); // R9
endmodule

// File: rtl/value_block_engine.sv
module value_block_engine
  import vbe_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [31:0]       cmdOperand,
  output logic              busy,
  output logic              done,
  output logic [1:0]        errCode,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [127:0]      memWdata,
  input  logic              memAck,
  input  logic [127:0]      memRdata
);
  vbe_strobe_t strb;
  vbe_op_e     opReg;
  logic        regValid;

  vbe_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .memAck(memAck), .regValid(regValid), .strb(strb), .opReg(opReg),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .busy(busy), .done(done)
  );

  vbe_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .opReg(opReg), .cmdOperand(cmdOperand),
    .memRdata(memRdata), .memWdata(memWdata), .regValid(regValid), .errCode(errCode)
  );
endmodule

// File: tb/test_value_block_engine.sv
module test_value_block_engine;
  localparam int AW = 6;
  localparam int NBLK = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [31:0] cmdOperand = '0;
  logic busy, done, memReq, memWe, memAck;
  logic [1:0] errCode;
  logic [AW-1:0] memAddr;
  logic [127:0] memWdata, memRdata;

  logic [127:0] mem [NBLK];
  logic [127:0] shadow [NBLK];
  int tests = 0;
  int fails = 0;
  int curOp = -1;
  // reference model state
  logic [31:0] refVal = '0;
  logic [7:0] refAddr = '0;
  bit refValid = 1'b0;

  always #10 clk = ~clk;

  value_block_engine #(.ADDR_W(AW)) i_value_block_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdOperand(cmdOperand), .busy(busy), .done(done), .errCode(errCode),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  // behavioural memory: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else if (memReq && !memAck) begin
      memAck <= 1'b1;
      memRdata <= mem[memAddr];
      if (memWe) mem[memAddr] <= memWdata;
    end else memAck <= 1'b0;
  end

  function automatic logic [127:0] mkBlk(input logic [31:0] v, input logic [7:0] a);
    return {~a, a, ~a, a, v, ~v, v};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock monitor against the model's view of the command in flight
  bit lastDone = 1'b0;
  always @(negedge clk) if (rstN) begin
    if (memWe && memReq && curOp != 3) check(0, "R6 write outside transfer", memWe, 0);
    if (memReq && curOp == 3 && !refValid) check(0, "R8 access on refused transfer", memReq, 0);
    if (done && lastDone) check(0, "R9 done longer than one cycle", 2, 1);
    lastDone = done;
  end

  task automatic runCmd(input int op, input int addr, input logic [31:0] operand, input string req);
    logic [127:0] src;
    logic [31:0] v, r;
    logic [7:0] a;
    int expErr;
    bit fmt;
    int waitCnt;
    src = mem[addr];
    v = src[31:0];
    a = src[103:96];
    fmt = (src[63:32] == ~v) && (src[95:64] == v) && (src[111:104] == ~a)
          && (src[119:112] == a) && (src[127:120] == ~a);
    expErr = 0;
    if (op == 3) begin
      if (!refValid) expErr = 3;
      else shadow[addr] = mkBlk(refVal, refAddr);
    end else if (!fmt) begin
      expErr = 1;
      refValid = 0;
    end else begin
      longint s;
      if (op == 0) s = longint'($signed(v)) + longint'($signed(operand));
      else if (op == 1) s = longint'($signed(v)) - longint'($signed(operand));
      else s = longint'($signed(v));
      if (s > 64'sd2147483647 || s < -64'sd2147483648) expErr = 2;
      else begin
        r = s[31:0];
        refVal = r;
        refAddr = a;
        refValid = 1;
      end
    end
    @(negedge clk);
    curOp = op;
    cmdValid = 1'b1; cmdOp = op[1:0]; cmdAddr = addr[AW-1:0]; cmdOperand = operand;
    @(negedge clk);
    cmdValid = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 50) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done, {req, " done"}, done, 1);
    check(errCode == expErr[1:0], {req, " errCode"}, errCode, expErr);
    begin
      bit same = 1'b1;
      for (int i = 0; i < NBLK; i++) if (mem[i] !== shadow[i]) same = 1'b0;
      check(same, {req, " memory image"}, mem[addr], shadow[addr]);
    end
    curOp = -1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBLK; i++) mem[i] = {4{32'h5A5A_0000 + i}};
    mem[1] = mkBlk(32'd100, 8'h15);
    mem[2] = mkBlk(-32'sd5, 8'h22);
    mem[3] = mkBlk(32'd7, 8'h31) ^ (128'h1 << 40);   // inverted value copy corrupted
    mem[4] = mkBlk(32'h7FFF_FFFF, 8'h33);
    mem[5] = mkBlk(32'd9, 8'h44) ^ (128'h1 << 115);  // second address copy corrupted
    mem[6] = mkBlk(32'h8000_0000, 8'h66);
    for (int i = 0; i < NBLK; i++) shadow[i] = mem[i];
    repeat (3) @(negedge clk);
    check(!done && !memReq && !busy, "R1 reset outputs", {done, memReq, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !memReq && !busy, "R1 idle after reset", {done, memReq, busy}, 0);
    runCmd(3, 9, 0, "R1 R8 transfer after reset");
    runCmd(2, 1, 0, "R5 restore");
    runCmd(3, 10, 0, "R6 transfer of restore");
    runCmd(0, 1, 32'd23, "R3 increment");
    runCmd(3, 11, 0, "R6 transfer of increment");
    runCmd(1, 2, 32'd10, "R4 decrement negative");
    runCmd(3, 12, 0, "R4 R6 transfer of decrement");
    runCmd(0, 12, -32'sd20, "R3 increment by negative");
    runCmd(3, 12, 0, "R6 overwrite destination");
    runCmd(0, 3, 32'd1, "R2 bad inverted value");
    runCmd(3, 13, 0, "R2 R8 transfer after format error");
    runCmd(2, 4, 0, "R5 restore max");
    runCmd(1, 5, 32'd1, "R2 bad address copy");
    runCmd(2, 4, 0, "R5 restore max again");
    runCmd(0, 4, 32'd1, "R7 increment overflow");
    runCmd(3, 14, 0, "R7 register kept after overflow");
    runCmd(1, 6, 32'd1, "R7 decrement overflow");
    runCmd(1, 6, -32'sd1, "R4 decrement by negative");
    runCmd(3, 15, 0, "R6 transfer after min value");
    // R9: a command presented while busy is ignored
    @(negedge clk);
    curOp = 0;
    cmdValid = 1'b1; cmdOp = 2'd0; cmdAddr = 6'd1; cmdOperand = 32'd1;
    @(negedge clk);
    cmdOp = 2'd3; cmdAddr = 6'd20;
    @(negedge clk);
    cmdValid = 1'b0;
    begin
      int n = 0;
      int pulses = 0;
      while (n < 20) begin
        if (done) pulses++;
        @(negedge clk);
        n++;
      end
      check(pulses == 1, "R9 one done per accepted command", pulses, 1);
    end
    refVal = 32'd101; refAddr = 8'h15; refValid = 1;
    check(mem[20] === shadow[20], "R9 busy command ignored", mem[20], shadow[20]);
    check(errCode == 2'd0, "R9 errCode held", errCode, 0);
    curOp = -1;
    runCmd(3, 21, 0, "R6 transfer after busy test");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule